// File: doc/BRIEF.md
# Operand Bypass and Hazard Stall Controller

This controller sits beside the decode stage of a five-stage in-order integer pipeline. Each cycle it looks at the two source register numbers of the instruction being decoded. It compares them with the destinations of the two older instructions still in flight: the one now in execute, and the one now in memory access. From that comparison it picks, one cycle ahead, where each ALU operand of that instruction will come from once it reaches execute. The choice is the register file, the EX/MEM pipeline register or the MEM/WB pipeline register. The selects are registered, so the decision is made in decode and presented for the whole execute cycle.

When the instruction in execute is a load and the decoded instruction reads its destination, bypassing cannot help. The controller raises hold controls for the program counter and the fetch/decode register. In the same cycle it asks the pipeline to turn the execute slot into a bubble, and it sets both of the next operand selects to the register file. After one such cycle the loaded value sits in MEM/WB and is bypassed from there. A taken branch resolved in decode makes the controller discard the slot that was fetched behind the branch. A load-use stall in the same cycle overrides that request.

The register file is assumed to write in the first half of a cycle and read in the second half. A result that has already reached write-back therefore needs no bypass.

Top module: `hz_ctrl`

## Requirements
- R1: While reset is low at a clock edge, both operand selects become 0 after that edge. Select encoding: 0 = register file, 1 = EX/MEM, 2 = MEM/WB.
- R2: If a decoded source equals `ex_rd`, `ex_reg_we` is 1, `ex_rd` is non-zero and no stall is raised, that operand's select is 1 after the next edge.
- R3: If a decoded source equals `mem_rd`, `mem_reg_we` is 1, `mem_rd` is non-zero and the execute producer does not match, that operand's select is 2 after the next edge.
- R4: When both producers match the same source, the select after the next edge is 1, because the younger result wins.
- R5: A destination of register 0, or a producer whose write enable is 0, never causes bypassing or a stall.
- R6: `pc_hold`, `ifid_hold` and `idex_bubble` are 1 in the same cycle exactly when `ex_is_load`, `ex_reg_we` and a non-zero `ex_rd` match either decoded source.
- R7: After a stall cycle both selects are 0 (the bubble). One cycle later, the load's destination seen through `mem_rd` gives select 2.
- R8: The two operands are judged independently, so each may come from a different source in the same cycle.
- R9: With `id_br_taken` at 1 and no stall, `ifid_flush` is 1 in that cycle and the hold outputs are 0.
- R10: When a stall and a taken branch fall in the same cycle, the holds are 1 and `ifid_flush` is 0.
- R11: An ALU-type producer (`ex_is_load` at 0) that matches a source never raises the hold outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | REG_AW | First source register of the instruction in decode |
| id_rs2 | input | REG_AW | Second source register of the instruction in decode |
| id_br_taken | input | 1 | Branch in decode resolved taken |
| ex_rd | input | REG_AW | Destination held in ID/EX |
| ex_reg_we | input | 1 | Register write enable held in ID/EX |
| ex_is_load | input | 1 | Instruction in ID/EX is a load |
| mem_rd | input | REG_AW | Destination held in EX/MEM |
| mem_reg_we | input | 1 | Register write enable held in EX/MEM |
| fwd_sel_a | output | 2 | Source select for ALU operand A of the instruction in execute |
| fwd_sel_b | output | 2 | Source select for ALU operand B of the instruction in execute |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Clear the write enables entering ID/EX |
| ifid_flush | output | 1 | Discard the slot fetched after a taken branch |

## Verification
Two functions can fall in the same cycle: the load-use interlock and the taken-branch flush. The bench provokes this by presenting a load in execute whose destination is a source of the decoded instruction while `id_br_taken` is also raised. The expected result is that all hold outputs are high, `ifid_flush` stays low, and the next operand selects show a bubble. A second overlap comes from both producers matching one source. In that case the select must name the EX/MEM result rather than MEM/WB.

// File: rtl/hz_pkg.sv
// Shared types for the hazard controller.
// Assumes two-bit operand select encoding consumed by the execute muxes.
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF    = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_MEMWB = 2'd2
    } fwd_src_e;
endpackage

// File: rtl/hz_src_pick.sv
// Chooses the bypass source for one decoded source register.
// Assumes producers are described by destination and write enable only;
// register 0 is hard-wired to zero and never bypassed.
module hz_src_pick
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    output fwd_src_e          sel,
    output logic              ex_hit
);
    logic mem_hit;

    // Match against each in-flight producer, excluding register 0.
    always_comb begin
        ex_hit  = ex_we  && (ex_rd  != '0) && (ex_rd  == src);
        mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
    end

    // Younger producer wins when both match.
    always_comb begin
        if (ex_hit)       sel = FWD_EXMEM;
        else if (mem_hit) sel = FWD_MEMWB;
        else              sel = FWD_RF;
    end
endmodule

// File: rtl/hz_interlock.sv
// Load-use interlock and branch refetch flush.
// Assumes hit flags already include write enable and non-zero destination.
module hz_interlock #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] ex_hits,
    input  logic               ex_is_load,
    input  logic               br_taken,
    output logic               stall,
    output logic               flush
);
    // A load feeding a decoded source needs one bubble; a stall cancels the flush.
    always_comb begin
        stall = ex_is_load && (|ex_hits);
        flush = br_taken && !stall;
    end
endmodule

// File: rtl/hz_ctrl.sv
// Hazard controller for a five-stage in-order pipeline: registers operand
// bypass selects decided in decode, raises load-use holds and the
// taken-branch flush. Assumes the register file writes before it reads.
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_br_taken,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_reg_we,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_reg_we,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble,
    output logic              ifid_flush
);
    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0]  srcs [NUM_SRC];
    fwd_src_e           sel_d [NUM_SRC];
    fwd_src_e           sel_q [NUM_SRC];
    logic [NUM_SRC-1:0] ex_hits;
    logic               stall;

    // Gather decoded sources into an indexable array.
    always_comb begin
        srcs[0] = id_rs1;
        srcs[1] = id_rs2;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hz_src_pick #(.REG_AW(REG_AW)) u_pick (
            .src    (srcs[i]),
            .ex_rd  (ex_rd),
            .ex_we  (ex_reg_we),
            .mem_rd (mem_rd),
            .mem_we (mem_reg_we),
            .sel    (sel_d[i]),
            .ex_hit (ex_hits[i])
        );

        // Select register: bubble on stall, otherwise the decode-time choice.
        always_ff @(posedge clk) begin
            if (!rst_n)     sel_q[i] <= FWD_RF;
            else if (stall) sel_q[i] <= FWD_RF;
            else            sel_q[i] <= sel_d[i];
        end
    end

    hz_interlock #(.NUM_SRC(NUM_SRC)) u_lock (
        .ex_hits    (ex_hits),
        .ex_is_load (ex_is_load),
        .br_taken   (id_br_taken),
        .stall      (stall),
        .flush      (ifid_flush)
    );

    // Drive the pipeline control outputs.
    always_comb begin
        fwd_sel_a   = sel_q[0];
        fwd_sel_b   = sel_q[1];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end
endmodule

// File: rtl/hz_ctrl_chk.sv
// Property checker for hz_ctrl, attached by bind.
module hz_ctrl_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] id_rs1,
    input logic [REG_AW-1:0] id_rs2,
    input logic              id_br_taken,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_reg_we,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_reg_we,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              pc_hold,
    input logic              ifid_hold,
    input logic              idex_bubble,
    input logic              ifid_flush
);
    p_ex_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_hold && ex_reg_we && ex_rd != '0 && ex_rd == id_rs1) |=> fwd_sel_a == 2'd1);

    p_mem_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_hold && mem_reg_we && mem_rd != '0 && mem_rd == id_rs2
         && !(ex_reg_we && ex_rd == id_rs2)) |=> fwd_sel_b == 2'd2);

    p_zero_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 && mem_rd == '0) |=> (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

    p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_is_load && ex_reg_we && ex_rd != '0
                     && (ex_rd == id_rs1 || ex_rd == id_rs2)));

    p_hold_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ifid_hold && idex_bubble));

    p_bubble_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (id_br_taken && !ex_is_load) |-> ifid_flush);

    p_stall_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> !pc_hold);

    p_no_alu_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !pc_hold);
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_br_taken(id_br_taken), .ex_rd(ex_rd), .ex_reg_we(ex_reg_we),
    .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .pc_hold(pc_hold),
    .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
);

// File: tb/hz_ctrl_test.sv
// Directed bench for hz_ctrl: one task per scenario.
module hz_ctrl_test;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
    logic          id_br_taken = 1'b0, ex_reg_we = 1'b0, ex_is_load = 1'b0, mem_reg_we = 1'b0;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          pc_hold, ifid_hold, idex_bubble, ifid_flush;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    hz_ctrl #(.REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_br_taken(id_br_taken), .ex_rd(ex_rd), .ex_reg_we(ex_reg_we),
        .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .pc_hold(pc_hold),
        .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one decode-cycle stimulus just after a falling edge.
    task automatic drive(input int rs1, input int rs2, input bit br,
                         input int erd, input bit ewe, input bit eld,
                         input int mrd, input bit mwe);
        @(negedge clk);
        id_rs1 = AW'(rs1); id_rs2 = AW'(rs2); id_br_taken = br;
        ex_rd = AW'(erd); ex_reg_we = ewe; ex_is_load = eld;
        mem_rd = AW'(mrd); mem_reg_we = mwe;
        #2;
    endtask

    task automatic chk_holds(input string tag, input int exp);
        chk({tag, " pc_hold"}, pc_hold, exp);
        chk({tag, " ifid_hold"}, ifid_hold, exp);
        chk({tag, " idex_bubble"}, idex_bubble, exp);
    endtask

    // Wait for the clock edge, then check the registered selects.
    task automatic chk_sel(input string tag, input int a, input int b);
        @(negedge clk);
        chk({tag, " sel_a"}, fwd_sel_a, a);
        chk({tag, " sel_b"}, fwd_sel_b, b);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(3, 3, 0, 3, 1, 0, 3, 1);
        chk_sel("R1 reset", 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        chk_sel("R1 after reset", 0, 0);
    endtask

    task automatic t_ex_fwd();
        drive(3, 7, 0, 3, 1, 0, 0, 0);
        chk_holds("R11 alu producer", 0);
        chk_sel("R2 exmem", 1, 0);
    endtask

    task automatic t_mem_fwd();
        drive(4, 9, 0, 0, 0, 0, 9, 1);
        chk_sel("R3 memwb", 0, 2);
    endtask

    task automatic t_both();
        drive(5, 5, 0, 5, 1, 0, 5, 1);
        chk_sel("R4 younger wins", 1, 1);
    endtask

    task automatic t_split();
        drive(6, 8, 0, 8, 1, 0, 6, 1);
        chk_sel("R8 independent", 2, 1);
    endtask

    task automatic t_zero();
        drive(0, 0, 0, 0, 1, 0, 0, 1);
        chk_sel("R5 reg zero", 0, 0);
        drive(10, 10, 0, 10, 0, 0, 10, 0);
        chk_sel("R5 no write enable", 0, 0);
        drive(0, 0, 0, 0, 1, 1, 0, 0);
        chk_holds("R5 load to reg zero", 0);
        chk_sel("R5 load to reg zero", 0, 0);
    endtask

    task automatic t_load_use();
        drive(1, 2, 0, 2, 1, 1, 0, 0);
        chk_holds("R6 load use", 1);
        chk("R6 no flush", ifid_flush, 0);
        chk_sel("R7 bubble", 0, 0);
        drive(1, 2, 0, 0, 0, 0, 2, 1);
        chk_holds("R7 released", 0);
        chk_sel("R7 load via memwb", 0, 2);
    endtask

    task automatic t_load_nodep();
        drive(3, 4, 0, 2, 1, 1, 0, 0);
        chk_holds("R6 independent load", 0);
        chk_sel("R6 independent load", 0, 0);
    endtask

    task automatic t_branch();
        drive(12, 13, 1, 0, 0, 0, 0, 0);
        chk("R9 flush", ifid_flush, 1);
        chk_holds("R9 no hold", 0);
        chk_sel("R9 sel", 0, 0);
    endtask

    task automatic t_collide();
        drive(11, 14, 1, 11, 1, 1, 14, 1);
        chk_holds("R10 stall wins", 1);
        chk("R10 flush suppressed", ifid_flush, 0);
        chk_sel("R10 bubble", 0, 0);
    endtask

    initial begin
        t_reset();
        t_ex_fwd();
        t_mem_fwd();
        t_both();
        t_split();
        t_zero();
        t_load_use();
        t_load_nodep();
        t_branch();
        t_collide();
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule